// File: doc/BRIEF.md
# External Interrupt and Wake-up Line Controller

This block gathers 21 event lines and turns their edges into latched interrupt requests. Sixteen of the lines come from general-purpose pins. A per-line port selector picks which of several pin ports drives line n; the pin number always equals the line number. The remaining five lines carry internal sources: a supply-voltage detector, two analog comparators, a real-time-clock wake signal and a low-power-timer wake signal.

Each line passes through an edge catcher that works without the system clock, so a pulse narrower than one clock period is not lost. The detected edge is synchronised into the clock domain, filtered by the line's rising and falling enables, and latched as a pending bit. Pending bits stay set until software clears them, so after stop mode the wake source can still be read. A line's interrupt output is its pending bit gated by its mask bit, and any active interrupt also raises the wake request. Configuration goes through a small word-addressed register bus with a combinational read port.

Top module: `exti_ctrl`

## Requirements
- R1: After reset, every pending bit, mask bit, falling enable and port selector is 0, `irq_o` and `wake_o` are 0, and the rising-enable register reads 0x0018_0000 (lines 19 and 20 only).
- R2: A 0-to-1 transition on a line whose rising enable is set sets that line's pending bit no later than the third rising clock edge after the transition.
- R3: A 1-to-0 transition sets the pending bit only when the falling enable is set. A line with both enables reacts to either edge. An edge whose enable is clear leaves the pending bit at 0.
- R4: A pulse that starts and ends between two rising clock edges is still captured on an enabled line.
- R5: Writing the pending register (address 3) clears each bit written as 1 and leaves bits written as 0 untouched. If a new edge on a line arrives in the same cycle as a clear of that line, the bit stays 1.
- R6: `irq_o[n]` is 1 exactly when line n is pending and mask bit n (address 2) is 1. A masked-off line still records its pending bit.
- R7: `wake_o` is 1 whenever any bit of `irq_o` is 1, and 0 otherwise.
- R8: GPIO line n (0 to 15) follows `gpio_i[16*p + n]`, where p is the 2-bit selector at bits [2n+1:2n] of address 4. Edges on pins of unselected ports have no effect.
- R9: Line 16 is the voltage detector, lines 17 and 18 are comparators 0 and 1, and all three honour their rising and falling enables.
- R10: Lines 19 (RTC wake) and 20 (low-power-timer wake) react only to rising edges. Their rising-enable bits read 1 and their falling-enable bits read 0, whatever is written.
- R11: The register map is: address 0 rising enables, 1 falling enables, 2 mask, 3 pending, 4 port selectors. Line n sits at bit n, and unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Active-high reset, synchronous for the datapath |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| gpio_i | input | 64 | Four ports of 16 pins; port p occupies bits [16p+15:16p] |
| vdet_i | input | 1 | Supply-voltage detector output (line 16) |
| cmp_i | input | 2 | Comparator outputs (lines 17 and 18) |
| rtc_wake_i | input | 1 | RTC wake pulse (line 19) |
| lptim_wake_i | input | 1 | Low-power-timer wake pulse (line 20) |
| irq_o | output | 21 | Per-line interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The hardest case to reach from the ports is an edge whose synchronised event lands in exactly the cycle in which software clears the same pending bit. The bench counts the synchroniser delay from the moment it drives the pin. It then places the clear write so that the write strobe is sampled on the same clock edge that latches the new event, and checks that the bit survives. A clear-only case next to it shows that the same write does clear the bit otherwise. Sub-clock pulses are driven as a one-nanosecond high phase placed between two clock edges, with no clock edge inside it.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int PINS        = 16;
    localparam int NPORTS      = 4;
    localparam int SEL_W       = $clog2(NPORTS);
    localparam int NLINES      = 21;
    localparam int DW          = 32;
    localparam int AW          = 3;
    localparam int SYNC_STAGES = 2;

    localparam int LINE_VDET   = 16;
    localparam int LINE_CMP0   = 17;
    localparam int LINE_RTC    = 19;
    localparam int LINE_LPT    = 20;

    typedef enum logic [AW-1:0] {
        REG_RISE = 3'd0,
        REG_FALL = 3'd1,
        REG_MASK = 3'd2,
        REG_PEND = 3'd3,
        REG_PSEL = 3'd4
    } reg_addr_e;

    typedef logic [NLINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t rise;
        line_vec_t fall;
        line_vec_t mask;
    } line_cfg_t;

    // Lines whose polarity is hard-wired to rising edge only
    function automatic line_vec_t fixed_rise_lines();
        line_vec_t v;
        v = '0;
        v[LINE_RTC] = 1'b1;
        v[LINE_LPT] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/exti_edge_capture.sv
module exti_edge_capture #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic line_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    output logic evt_o
);

    // Toggle flops clocked by the line itself: each edge flips one bit,
    // so a pulse shorter than a clock period leaves a lasting change.
    logic rise_tog;
    logic fall_tog;

    always_ff @(posedge line_i or posedge rst_i) begin
        if (rst_i) rise_tog <= 1'b0;
        else       rise_tog <= ~rise_tog;
    end

    always_ff @(negedge line_i or posedge rst_i) begin
        if (rst_i) fall_tog <= 1'b0;
        else       fall_tog <= ~fall_tog;
    end

    // STAGES synchroniser flops plus one history flop per toggle
    logic [STAGES:0] rise_sh;
    logic [STAGES:0] fall_sh;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rise_sh <= '0;
            fall_sh <= '0;
        end else begin
            rise_sh <= {rise_sh[STAGES-1:0], rise_tog};
            fall_sh <= {fall_sh[STAGES-1:0], fall_tog};
        end
    end

    logic rise_seen;
    logic fall_seen;

    always_comb begin
        rise_seen = rise_sh[STAGES] ^ rise_sh[STAGES-1];
        fall_seen = fall_sh[STAGES] ^ fall_sh[STAGES-1];
        evt_o     = (rise_en_i & rise_seen) | (fall_en_i & fall_seen);
    end

endmodule

// File: rtl/exti_port_mux.sv
module exti_port_mux
    import exti_pkg::*;
(
    input  logic [NPORTS*PINS-1:0] gpio_i,
    input  logic [PINS*SEL_W-1:0]  sel_i,
    output logic [PINS-1:0]        line_o
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic [NPORTS-1:0] column;
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            assign column[p] = gpio_i[p*PINS + g];
        end
        assign line_o[g] = column[sel_i[g*SEL_W +: SEL_W]];
    end

endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  we_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [DW-1:0]         wdata_i,
    input  line_vec_t             evt_i,
    output line_cfg_t             cfg_o,
    output line_vec_t             pend_o,
    output logic [PINS*SEL_W-1:0] psel_o,
    output logic [DW-1:0]         rdata_o
);

    localparam line_vec_t FIXED = fixed_rise_lines();

    line_cfg_t             cfg_q;
    line_vec_t             pend_q;
    logic [PINS*SEL_W-1:0] psel_q;
    line_vec_t             clr_vec;
    line_vec_t             wline;

    always_comb begin
        wline   = wdata_i[NLINES-1:0];
        clr_vec = (we_i && addr_i == REG_PEND) ? wline : '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q.rise <= FIXED;
            cfg_q.fall <= '0;
            cfg_q.mask <= '0;
            psel_q     <= '0;
            pend_q     <= '0;
        end else begin
            if (we_i) begin
                case (addr_i)
                    REG_RISE: cfg_q.rise <= wline | FIXED;
                    REG_FALL: cfg_q.fall <= wline & ~FIXED;
                    REG_MASK: cfg_q.mask <= wline;
                    REG_PSEL: psel_q     <= wdata_i[PINS*SEL_W-1:0];
                    default:  ;
                endcase
            end
            // a fresh event outranks a clear in the same cycle
            pend_q <= (pend_q & ~clr_vec) | evt_i;
        end
    end

    always_comb begin
        case (addr_i)
            REG_RISE: rdata_o = DW'(cfg_q.rise);
            REG_FALL: rdata_o = DW'(cfg_q.fall);
            REG_MASK: rdata_o = DW'(cfg_q.mask);
            REG_PEND: rdata_o = DW'(pend_q);
            REG_PSEL: rdata_o = DW'(psel_q);
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o  = cfg_q;
    assign pend_o = pend_q;
    assign psel_o = psel_q;

endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   bus_we_i,
    input  logic [AW-1:0]          bus_addr_i,
    input  logic [DW-1:0]          bus_wdata_i,
    output logic [DW-1:0]          bus_rdata_o,
    input  logic [NPORTS*PINS-1:0] gpio_i,
    input  logic                   vdet_i,
    input  logic [1:0]             cmp_i,
    input  logic                   rtc_wake_i,
    input  logic                   lptim_wake_i,
    output logic [NLINES-1:0]      irq_o,
    output logic                   wake_o
);

    line_cfg_t             cfg_w;
    line_vec_t             pend_w;
    line_vec_t             evt_w;
    line_vec_t             src_w;
    logic [PINS*SEL_W-1:0] psel_w;
    logic [PINS-1:0]       gpio_line_w;
    logic                  clr_we_w;

    exti_port_mux u_mux (
        .gpio_i (gpio_i),
        .sel_i  (psel_w),
        .line_o (gpio_line_w)
    );

    always_comb begin
        src_w                = '0;
        src_w[PINS-1:0]      = gpio_line_w;
        src_w[LINE_VDET]     = vdet_i;
        src_w[LINE_CMP0]     = cmp_i[0];
        src_w[LINE_CMP0+1]   = cmp_i[1];
        src_w[LINE_RTC]      = rtc_wake_i;
        src_w[LINE_LPT]      = lptim_wake_i;
    end

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        exti_edge_capture #(.STAGES(SYNC_STAGES)) u_cap (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .line_i    (src_w[n]),
            .rise_en_i (cfg_w.rise[n]),
            .fall_en_i (cfg_w.fall[n]),
            .evt_o     (evt_w[n])
        );
    end

    exti_regs u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .evt_i   (evt_w),
        .cfg_o   (cfg_w),
        .pend_o  (pend_w),
        .psel_o  (psel_w),
        .rdata_o (bus_rdata_o)
    );

    assign clr_we_w = bus_we_i && (bus_addr_i == REG_PEND);
    assign irq_o    = pend_w & cfg_w.mask;
    assign wake_o   = |irq_o;

endmodule

// File: rtl/exti_ctrl_chk.sv
module exti_ctrl_chk
    import exti_pkg::*;
(
    input logic      clk_i,
    input logic      rst_i,
    input line_vec_t evt_i,
    input line_vec_t pend_i,
    input logic      clr_we_i,
    input line_vec_t wclr_i
);

    // R2: a synchronised event is latched on the next edge
    assert_evt_latched_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_i != '0) |=> ((pend_i & $past(evt_i)) == $past(evt_i)));

    // R2: no pending bit rises without an event behind it
    assert_rise_has_cause_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ((pend_i & ~$past(pend_i) & ~$past(evt_i)) == '0));

    // R5: cleared bits without a competing event are 0 afterwards
    assert_clear_works_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_we_i |=> ((pend_i & $past(wclr_i & ~evt_i)) == '0));

    // R5: without clear or event the pending register holds
    assert_pend_holds_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_we_i && evt_i == '0) |=> $stable(pend_i));

endmodule

bind exti_ctrl exti_ctrl_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .evt_i    (evt_w),
    .pend_i   (pend_w),
    .clr_we_i (clr_we_w),
    .wclr_i   (bus_wdata_i[exti_pkg::NLINES-1:0])
);

// File: tb/tb_exti_ctrl.sv
`timescale 1ns/1ps
module tb_exti_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [63:0] gpio;
    logic        vdet;
    logic [1:0]  cmp;
    logic        rtc;
    logic        lpt;
    logic [20:0] irq;
    logic        wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    exti_ctrl dut (
        .clk_i(clk), .rst_i(rst), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .gpio_i(gpio),
        .vdet_i(vdet), .cmp_i(cmp), .rtc_wake_i(rtc), .lptim_wake_i(lpt),
        .irq_o(irq), .wake_o(wake)
    );

    typedef struct packed {
        logic [4:0] ln;
        logic       r;
        logic       f;
        logic       m;
        logic [1:0] kind;   // 0 rise, 1 fall, 2 short pulse
        logic       ep;
        logic       ei;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},
        '{5'd3,  1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0},
        '{5'd7,  1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1},
        '{5'd7,  1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0},
        '{5'd9,  1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0},
        '{5'd12, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1},
        '{5'd16, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},
        '{5'd17, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1},
        '{5'd18, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1},
        '{5'd19, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},
        '{5'd20, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
        '{5'd0,  1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0},
        '{5'd15, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input int ln, input logic v);
        if (ln < 16)       gpio[ln] = v;
        else if (ln == 16) vdet = v;
        else if (ln == 17) cmp[0] = v;
        else if (ln == 18) cmp[1] = v;
        else if (ln == 19) rtc = v;
        else               lpt = v;
    endtask

    logic [31:0] v;

    initial begin
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
        gpio = '0; vdet = 1'b0; cmp = '0; rtc = 1'b0; lpt = 1'b0;
        wait_clk(3);
        rst = 1'b0;

        // R1 reset state, R11 map
        rd(3'd0, v); chk("R1 rise reset", v, 32'h0018_0000);
        rd(3'd1, v); chk("R1 fall reset", v, 32'h0);
        rd(3'd2, v); chk("R1 mask reset", v, 32'h0);
        rd(3'd3, v); chk("R1 pend reset", v, 32'h0);
        rd(3'd4, v); chk("R1 psel reset", v, 32'h0);
        chk("R1 irq reset", {11'd0, irq}, 32'h0);
        chk("R1 wake reset", {31'd0, wake}, 32'h0);
        rd(3'd7, v); chk("R11 unmapped read", v, 32'h0);

        // R10 fixed polarity bits
        wr(3'd0, 32'h0);        rd(3'd0, v); chk("R10 rise fixed", v, 32'h0018_0000);
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R10 fall fixed R11", v, 32'h0007_FFFF);
        wr(3'd1, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t t;
            logic [31:0] bit_n;
            t = VECS[i];
            bit_n = 32'h1 << t.ln;
            wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
            drive(t.ln, t.kind == 2'd1);
            wait_clk(6);
            wr(3'd3, 32'hFFFF_FFFF);
            wr(3'd0, t.r ? bit_n : 32'h0);
            wr(3'd1, t.f ? bit_n : 32'h0);
            wr(3'd2, t.m ? bit_n : 32'h0);
            @(negedge clk);
            if (t.kind == 2'd0)      drive(t.ln, 1'b1);
            else if (t.kind == 2'd1) drive(t.ln, 1'b0);
            else begin drive(t.ln, 1'b1); #1; drive(t.ln, 1'b0); end
            wait_clk(6);
            rd(3'd3, v);
            chk($sformatf("R2 R3 R4 R9 R10 vec%0d pend", i), v, t.ep ? bit_n : 32'h0);
            chk($sformatf("R6 vec%0d irq", i), {11'd0, irq}, t.ei ? bit_n : 32'h0);
            chk($sformatf("R7 vec%0d wake", i), {31'd0, wake}, {31'd0, t.ei});
            drive(t.ln, 1'b0);
            wait_clk(6);
        end
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);

        // R5 selective clear
        wr(3'd0, 32'h6);
        @(negedge clk); gpio[1] = 1'b1; gpio[2] = 1'b1;
        wait_clk(6);
        rd(3'd3, v); chk("R5 both set", v, 32'h6);
        wr(3'd3, 32'h2);
        rd(3'd3, v); chk("R5 selective clear", v, 32'h4);

        // R6 R7 mask applied after pending
        wr(3'd3, 32'hFFFF_FFFF);
        @(negedge clk); gpio[1] = 1'b0; gpio[2] = 1'b0;
        wait_clk(2);
        @(negedge clk); gpio[1] = 1'b1; gpio[2] = 1'b1;
        wait_clk(6);
        chk("R6 masked irq", {11'd0, irq}, 32'h0);
        chk("R7 masked wake", {31'd0, wake}, 32'h0);
        wr(3'd2, 32'h4);
        #1;
        chk("R6 mask enables irq", {11'd0, irq}, 32'h4);
        chk("R7 wake from one line", {31'd0, wake}, 32'h1);
        wr(3'd2, 32'h0);
        gpio[1] = 1'b0; gpio[2] = 1'b0;
        wr(3'd0, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);

        // R5 edge during clear wins
        wr(3'd0, 32'h10);
        @(negedge clk); gpio[4] = 1'b1;
        wait_clk(6);
        gpio[4] = 1'b0;
        wait_clk(6);
        @(negedge clk); gpio[4] = 1'b1;     // before e1
        @(negedge clk);                     // after e1
        @(negedge clk);                     // after e2: event visible
        we = 1'b1; addr = 3'd3; wdata = 32'h10;
        @(negedge clk);                     // after e3
        we = 1'b0;
        rd(3'd3, v); chk("R5 edge beats clear", v, 32'h10);
        wr(3'd3, 32'h10);
        rd(3'd3, v); chk("R5 clear alone", v, 32'h0);
        gpio[4] = 1'b0;
        wait_clk(4);
        wr(3'd0, 32'h0);

        // R8 port select: line 5 from port 2
        wr(3'd4, 32'h0000_0800);
        rd(3'd4, v); chk("R8 psel readback", v, 32'h0000_0800);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h20);
        @(negedge clk); gpio[5] = 1'b1;
        wait_clk(6);
        rd(3'd3, v); chk("R8 unselected port ignored", v, 32'h0);
        @(negedge clk); gpio[2*16+5] = 1'b1;
        wait_clk(6);
        rd(3'd3, v); chk("R8 selected port", v, 32'h20);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule